// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block stands in for the serial output side of a small successive-approximation converter. A parallel sample word is provided by surrounding logic. A host, acting as bus master, pulls the active-low select line low and toggles a serial clock. The block then plays out a 16-clock frame on a serial data line that the host can switch to three-state. The frame holds four leading zeros, then the sample with the most significant bit first, then enough trailing zeros to fill sixteen clocks. A separate status output reports whether the emulated sampler is in hold or in track during the frame.

The host's select and serial clock lines are sampled on the block's own system clock, and edges are found by comparing each input with its registered copy. The line enable and the first leading zero are derived combinationally from the select input, so they appear in the same system-clock cycle in which select drops. The sequencer uses five named states. IDLE moves to LEAD on a select fall. LEAD moves to DATA after four serial-clock falls. DATA moves to TRAIL, or straight to DONE when the resolution is 12, after the last data bit. TRAIL moves to DONE on the sixteenth fall. Any active state moves back to IDLE when select is raised, and this abandons the frame. The track/hold tracker has two states. TRACK moves to HOLD on a select fall. HOLD moves back to TRACK on rising serial-clock edge number RES+3, or when select is raised.

Top module: `adc_serial_out_emu`

## Requirements
- R1: After reset, `sdo_oe` and `hold` are both 0.
- R2: In the system-clock cycle in which `cs_n` falls, `sdo_oe` is 1 and `sdo` is 0, before any serial-clock edge.
- R3: After k falling edges of `sclk` in a frame (1 ≤ k ≤ 15), `sdo` shows bit k of the stream. Bits 0 to 3 are 0. Bits 4 to 3+RES are `sample_in[RES-1]` down to `sample_in[0]`. Every later bit is 0.
- R4: From the 16th falling edge of `sclk` until `cs_n` rises, `sdo_oe` is 0, and further `sclk` edges do not re-enable it.
- R5: Raising `cs_n` before the 16th fall drops `sdo_oe` to 0 in the same cycle and returns `hold` to 0 one cycle later. The next frame restarts at bit 0.
- R6: `sample_in` is captured when `cs_n` falls. Changing it during a frame does not alter the bits played out.
- R7: `sdo_oe` is 0 whenever `cs_n` is high.
- R8: `hold` is 1 from the cycle after a `cs_n` fall until the (RES+3)th rising edge of `sclk` in that frame, and is 0 from the cycle after that edge.
- R9: The frame carries 16-4-RES trailing zeros, driven with `sdo_oe` at 1.
- R10: `sclk` activity while `cs_n` is high starts no frame, leaves `sdo_oe` and `hold` at 0, and does not advance the bit position of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample_in | input | RES | Parallel sample word to be played out |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Drive enable for the serial data line (0 means three-state) |
| hold | output | 1 | 1 while the emulated sampler is in hold |

## Verification
The bench builds the block with RES set to 10. This leaves two trailing zeros in every frame and moves the track edge to the 13th rising clock, so the LEAD, DATA and TRAIL states, the DATA-to-TRAIL transition and the trailing-zero region are all observed. The default RES of 8 is covered only by elaboration. The vector table mixes full frames with frames abandoned in the leading zeros, in the middle of the data and in the trailing zeros. It changes the sample word in the middle of every frame, so capture timing and counter restart are both exercised.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    typedef enum logic [2:0] {
        FR_IDLE  = 3'd0,
        FR_LEAD  = 3'd1,
        FR_DATA  = 3'd2,
        FR_TRAIL = 3'd3,
        FR_DONE  = 3'd4
    } frame_st_t;

    typedef enum logic {
        TH_TRACK = 1'b0,
        TH_HOLD  = 1'b1
    } th_st_t;

endpackage

// File: rtl/adc_emu_edges.sv
module adc_emu_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic cs_fall,
    output logic sclk_rise,
    output logic sclk_fall
);

    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    assign cs_fall   = cs_q & ~cs_n;
    assign sclk_rise = ~sclk_q & sclk;
    assign sclk_fall = sclk_q & ~sclk;

endmodule

// File: rtl/adc_emu_framer.sv
module adc_emu_framer
    import adc_emu_pkg::*;
#(
    parameter int RES       = 8,
    parameter int LEAD      = 4,
    parameter int FRAME_LEN = 16,
    parameter int CW        = $clog2(FRAME_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            cs_fall,
    input  logic            sclk_fall,
    input  logic [RES-1:0]  sample_in,
    output frame_st_t       frame_st,
    output logic [CW-1:0]   bit_cnt,
    output logic [RES-1:0]  sample_q
);

    localparam int DATA_END = LEAD + RES;

    frame_st_t      st_nxt;
    logic [CW-1:0]  cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_st <= FR_IDLE;
            bit_cnt  <= '0;
        end else begin
            frame_st <= st_nxt;
            bit_cnt  <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = frame_st;
        cnt_nxt = bit_cnt;
        unique case (frame_st)
            FR_IDLE: begin
                if (cs_fall) begin
                    st_nxt  = FR_LEAD;
                    cnt_nxt = '0;
                end
            end
            FR_LEAD, FR_DATA, FR_TRAIL: begin
                if (cs_n) begin
                    st_nxt  = FR_IDLE;
                    cnt_nxt = '0;
                end else if (sclk_fall) begin
                    cnt_nxt = bit_cnt + 1'b1;
                    if (cnt_nxt == CW'(FRAME_LEN))
                        st_nxt = FR_DONE;
                    else if (cnt_nxt == CW'(DATA_END))
                        st_nxt = FR_TRAIL;
                    else if (cnt_nxt == CW'(LEAD))
                        st_nxt = FR_DATA;
                end
            end
            FR_DONE: begin
                if (cs_n) begin
                    st_nxt  = FR_IDLE;
                    cnt_nxt = '0;
                end
            end
            default: begin
                st_nxt  = FR_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sample_q <= '0;
        else if (cs_fall && frame_st == FR_IDLE)
            sample_q <= sample_in;
    end

    a_r6_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_st != FR_IDLE) |=> $stable(sample_q));

    a_r3_data_window: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_st == FR_DATA) |-> (bit_cnt >= CW'(LEAD) && bit_cnt < CW'(DATA_END)));

    a_r4_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(FRAME_LEN));

endmodule

// File: rtl/adc_emu_bitsel.sv
module adc_emu_bitsel
    import adc_emu_pkg::*;
#(
    parameter int RES  = 8,
    parameter int LEAD = 4,
    parameter int CW   = 5
) (
    input  logic            cs_n,
    input  logic            cs_fall,
    input  frame_st_t       frame_st,
    input  logic [CW-1:0]   bit_cnt,
    input  logic [RES-1:0]  sample_q,
    output logic            sdo,
    output logic            sdo_oe
);

    logic [RES-1:0] bit_hit;

    for (genvar gi = 0; gi < RES; gi++) begin : g_pos
        assign bit_hit[gi] = (bit_cnt == CW'(LEAD + RES - 1 - gi));
    end

    always_comb begin
        unique case (frame_st)
            FR_IDLE:                    sdo_oe = ~cs_n & cs_fall;
            FR_LEAD, FR_DATA, FR_TRAIL: sdo_oe = ~cs_n;
            FR_DONE:                    sdo_oe = 1'b0;
            default:                    sdo_oe = 1'b0;
        endcase
        sdo = (frame_st == FR_DATA) ? |(bit_hit & sample_q) : 1'b0;
    end

endmodule

// File: rtl/adc_emu_trackhold.sv
module adc_emu_trackhold
    import adc_emu_pkg::*;
#(
    parameter int TRACK_EDGE = 11,
    parameter int RW         = $clog2(TRACK_EDGE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic cs_fall,
    input  logic sclk_rise,
    output logic hold
);

    th_st_t         th_st, th_nxt;
    logic [RW-1:0]  rise_cnt, rise_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            th_st    <= TH_TRACK;
            rise_cnt <= '0;
        end else begin
            th_st    <= th_nxt;
            rise_cnt <= rise_nxt;
        end
    end

    always_comb begin
        th_nxt   = th_st;
        rise_nxt = rise_cnt;
        unique case (th_st)
            TH_TRACK: begin
                if (cs_fall) begin
                    th_nxt   = TH_HOLD;
                    rise_nxt = '0;
                end
            end
            TH_HOLD: begin
                if (cs_n) begin
                    th_nxt   = TH_TRACK;
                    rise_nxt = '0;
                end else if (sclk_rise) begin
                    rise_nxt = rise_cnt + 1'b1;
                    if (rise_nxt == RW'(TRACK_EDGE))
                        th_nxt = TH_TRACK;
                end
            end
            default: th_nxt = TH_TRACK;
        endcase
    end

    assign hold = (th_st == TH_HOLD);

    a_r8_hold_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> hold);

    a_r5_release_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !hold);

endmodule

// File: rtl/adc_serial_out_emu.sv
module adc_serial_out_emu
    import adc_emu_pkg::*;
#(
    parameter int RES       = 8,
    parameter int LEAD      = 4,
    parameter int FRAME_LEN = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic [RES-1:0] sample_in,
    output logic           sdo,
    output logic           sdo_oe,
    output logic           hold
);

    localparam int CW         = $clog2(FRAME_LEN + 1);
    localparam int DATA_END   = LEAD + RES;
    localparam int TRACK_EDGE = LEAD + RES - 1;

    logic           cs_fall, sclk_rise, sclk_fall;
    frame_st_t      frame_st;
    logic [CW-1:0]  bit_cnt;
    logic [RES-1:0] sample_q;

    adc_emu_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    adc_emu_framer #(
        .RES       (RES),
        .LEAD      (LEAD),
        .FRAME_LEN (FRAME_LEN),
        .CW        (CW)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall),
        .sample_in (sample_in),
        .frame_st  (frame_st),
        .bit_cnt   (bit_cnt),
        .sample_q  (sample_q)
    );

    adc_emu_bitsel #(
        .RES  (RES),
        .LEAD (LEAD),
        .CW   (CW)
    ) u_bitsel (
        .cs_n     (cs_n),
        .cs_fall  (cs_fall),
        .frame_st (frame_st),
        .bit_cnt  (bit_cnt),
        .sample_q (sample_q),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    adc_emu_trackhold #(
        .TRACK_EDGE (TRACK_EDGE)
    ) u_th (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .hold      (hold)
    );

    a_r4_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_st == FR_DONE) |-> !sdo_oe);

    a_r7_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdo_oe);

    a_r9_trailing_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && frame_st != FR_IDLE && bit_cnt >= CW'(DATA_END)) |-> !sdo);

    a_r2_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && bit_cnt < CW'(LEAD)) |-> !sdo);

endmodule

// File: tb/adc_serial_out_emu_tb.sv
module adc_serial_out_emu_tb_top;

    localparam int B_RES  = 10;
    localparam int B_LEAD = 4;
    localparam int B_TE   = B_LEAD + B_RES - 1;
    localparam int NVEC   = 9;

    // each entry: {sample word, number of falls before select is raised (0 = full frame)}
    localparam logic [B_RES+4-1:0] VEC [NVEC] = '{
        {10'h3FF, 4'd0},
        {10'h000, 4'd0},
        {10'h2AA, 4'd0},
        {10'h155, 4'd0},
        {10'h201, 4'd5},
        {10'h3C3, 4'd9},
        {10'h1F0, 4'd2},
        {10'h2CC, 4'd15},
        {10'h0FF, 4'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1;
    logic             sclk = 1'b0;
    logic [B_RES-1:0] sample_in = '0;
    logic             sdo, sdo_oe, hold;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_serial_out_emu #(.RES(B_RES)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sample_in (sample_in),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .hold      (hold)
    );

    function automatic logic exp_bit(int k, logic [B_RES-1:0] s);
        if (k >= B_LEAD && k < B_LEAD + B_RES) return s[B_RES-1-(k-B_LEAD)];
        return 1'b0;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic one_fall();
        @(negedge clk) sclk = 1'b1;
        @(negedge clk) sclk = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic run_frame(logic [B_RES-1:0] s, int ab);
        @(negedge clk);
        cs_n = 1'b0;
        sample_in = s;
        #1;
        chk("R2 oe", sdo_oe, 1'b1);
        chk("R2 sdo", sdo, 1'b0);
        @(negedge clk);
        #1;
        chk("R8 hold", hold, 1'b1);
        for (int k = 1; k <= 16; k++) begin
            if (ab != 0 && k > ab) break;
            one_fall();
            if (k == 2) sample_in = ~s; // R6: change during frame
            if (k < 16) begin
                chk("R3 oe", sdo_oe, 1'b1);
                if (k >= B_LEAD + B_RES) chk("R9 trail", sdo, 1'b0);
                else chk("R3 sdo", sdo, exp_bit(k, s));
            end else begin
                chk("R4 oe", sdo_oe, 1'b0);
            end
            chk("R8 hold", hold, (k < B_TE) ? 1'b1 : 1'b0);
        end
        if (ab != 0) begin
            @(negedge clk);
            cs_n = 1'b1;
            #1;
            chk("R5 oe", sdo_oe, 1'b0);
            @(negedge clk);
            #1;
            chk("R5 hold", hold, 1'b0);
        end else begin
            one_fall();
            chk("R4 extra", sdo_oe, 1'b0);
            @(negedge clk);
            cs_n = 1'b1;
            #1;
            chk("R7 oe", sdo_oe, 1'b0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 oe", sdo_oe, 1'b0);
        chk("R1 hold", hold, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 oe", sdo_oe, 1'b0);

        for (int v = 0; v < NVEC; v++)
            run_frame(VEC[v][B_RES+3:4], int'(VEC[v][3:0]));

        // R10: clocking with select high
        for (int i = 0; i < 7; i++) begin
            one_fall();
            chk("R10 oe", sdo_oe, 1'b0);
            chk("R10 hold", hold, 1'b0);
        end
        run_frame(10'h3A5, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule